// File: doc/BRIEF.md
# Memory-to-I/O Direct Transfer Controller

This block moves a run of bytes from memory to an I/O unit without involving the processor. An incoming transfer request makes the controller ask the processor to give up the bus. It holds that request until the processor grants the bus. It then makes one address phase, which puts a 12-bit memory address on the bus. After that it repeats a loop of three phases for every byte:

- a data phase, in which the memory byte is passed to the data output;
- an acknowledge phase, in which the I/O unit is acknowledged and its active-low strobe is pulsed;
- a check phase, which samples the last-byte input.

If the last-byte input is low in the check phase, the address counter steps by one and the loop goes back to the data phase. If it is high, the controller releases the bus and returns to idle.

The sequencer is a six-state Moore machine with state codes 0 to 5:

| Code | Phase |
|------|-------|
| 0 | idle |
| 1 | wait for grant |
| 2 | address |
| 3 | data |
| 4 | acknowledge |
| 5 | check |

All outputs are combinational functions of the current state, and the data output also depends on the memory read data. The reset input is asynchronous and active low. Its release is synchronised inside the block, so the controller leaves reset two clocks after the pin rises.

Top module: `dma_mem2io_ctrl`

## Requirements
- R1: While `rst_n` is low, and immediately after it falls in any state, the controller is idle: `hold_req`=0, `addr_en_n`=1, `addr_stb`=0, `dout`=0, `io_ack`=0, `io_strobe_n`=1 and `addr`=0.
- R2: In idle all outputs rest at the values of R1 except `addr`. A high `xfer_req` sampled in idle moves the controller to the grant wait. `xfer_req` is ignored in every other state.
- R3: In the grant wait the controller stays until `bus_grant` is sampled high. `bus_grant` is ignored outside the grant wait. `hold_req` is high in every state except idle, and it falls on the same edge that re-enters idle.
- R4: For exactly one cycle after the grant, `addr_en_n`=0 and `addr_stb`=1. This address phase is followed unconditionally by one data cycle, one acknowledge cycle and one check cycle.
- R5: `dout` equals `mem_rdata` during a data cycle and is 0 in every other cycle.
- R6: In the acknowledge cycle `io_ack`=1 and `io_strobe_n`=0. These levels occur in no other cycle.
- R7: In the check cycle, `last_byte`=1 returns the controller to idle, and `last_byte`=0 goes back to a data cycle without a new address phase. `last_byte` is ignored in every other state.
- R8: `addr` is loaded from `start_addr` on every clock edge taken in idle. It holds its value otherwise, except that it increments by one, modulo 4096, on each edge that leaves a check cycle back toward a data cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_req | input | 1 | Transfer request from the I/O unit |
| bus_grant | input | 1 | Bus grant from the processor |
| last_byte | input | 1 | End of run, sampled in the check cycle |
| start_addr | input | 12 | First memory address of the run |
| mem_rdata | input | 8 | Byte read from memory |
| hold_req | output | 1 | Bus hold request to the processor |
| addr_en_n | output | 1 | Address enable, active low |
| addr_stb | output | 1 | Address strobe |
| dout | output | 8 | Byte passed to the I/O unit |
| io_ack | output | 1 | Acknowledge to the I/O unit |
| io_strobe_n | output | 1 | I/O output strobe, active low |
| addr | output | 12 | Current memory address |

## Verification
The embedded properties check the following on every cycle:

- the request, grant-wait, address-to-data and end-of-run transitions;
- the rule that the address steps by one on every loop repeat;
- the drop of the hold request on the edge that exits the run;
- the rule that an acknowledge always follows a data cycle.

Only the bench scenarios can show the rest: the exact output vector of each cycle in a three-byte run; the loop skipping the address phase; the counter wrapping past 4095; inputs being ignored in the states that do not sample them; a back-to-back request on the exit edge; and an asynchronous reset taken in the middle of a run.

// File: rtl/dma_m2io_pkg.sv
package dma_m2io_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HOLD = 3'd1,
    ST_ADDR = 3'd2,
    ST_DATA = 3'd3,
    ST_ACK  = 3'd4,
    ST_CHK  = 3'd5
  } dma_state_e;

endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain[gi] <= 1'b0;
          else         chain[gi] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain[gi] <= 1'b0;
          else         chain[gi] <= chain[gi-1];
        end
      end
    end
  endgenerate

  assign srst_n = chain[STAGES-1];

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_m2io_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xfer_req,
  input  logic       bus_grant,
  input  logic       last_byte,
  output dma_state_e state,
  output logic       loop_back
);

  dma_state_e state_nxt;

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_IDLE: state_nxt = xfer_req  ? ST_HOLD : ST_IDLE;
      ST_HOLD: state_nxt = bus_grant ? ST_ADDR : ST_HOLD;
      ST_ADDR: state_nxt = ST_DATA;
      ST_DATA: state_nxt = ST_ACK;
      ST_ACK:  state_nxt = ST_CHK;
      ST_CHK:  state_nxt = last_byte ? ST_IDLE : ST_DATA;
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nxt;
  end

  assign loop_back = (state == ST_CHK) && !last_byte;

  AST_REQ_TO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && xfer_req) |=> (state == ST_HOLD)); // R2
  AST_WAIT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && !bus_grant) |=> (state == ST_HOLD)); // R3
  AST_ADDR_TO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR) |=> (state == ST_DATA)); // R4
  AST_END_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CHK && last_byte) |=> (state == ST_IDLE)); // R7

endmodule

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              step_en,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] addr_nxt;
  logic              addr_ce;

  assign addr_ce = load_en || step_en;

  always_comb begin
    if (load_en) addr_nxt = start_addr;
    else         addr_nxt = addr + {{(ADDR_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr <= '0;
    else if (addr_ce) addr <= addr_nxt;
  end

endmodule

// File: rtl/dma_phase_dec.sv
module dma_phase_dec
  import dma_m2io_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  dma_state_e        state,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              hold_req,
  output logic              addr_en_n,
  output logic              addr_stb,
  output logic [DATA_W-1:0] dout,
  output logic              io_ack,
  output logic              io_strobe_n
);

  always_comb begin
    hold_req    = 1'b1;
    addr_en_n   = 1'b1;
    addr_stb    = 1'b0;
    dout        = '0;
    io_ack      = 1'b0;
    io_strobe_n = 1'b1;
    unique case (state)
      ST_IDLE: hold_req = 1'b0;
      ST_ADDR: begin
        addr_en_n = 1'b0;
        addr_stb  = 1'b1;
      end
      ST_DATA: dout = mem_rdata;
      ST_ACK: begin
        io_ack      = 1'b1;
        io_strobe_n = 1'b0;
      end
      ST_HOLD, ST_CHK: ;
      default: hold_req = 1'b0;
    endcase
  end

endmodule

// File: rtl/dma_mem2io_ctrl.sv
module dma_mem2io_ctrl
  import dma_m2io_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 8,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_req,
  input  logic              bus_grant,
  input  logic              last_byte,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              hold_req,
  output logic              addr_en_n,
  output logic              addr_stb,
  output logic [DATA_W-1:0] dout,
  output logic              io_ack,
  output logic              io_strobe_n,
  output logic [ADDR_W-1:0] addr
);

  logic       rst_sync_n;
  dma_state_e state;
  logic       loop_back;
  logic       load_en;

  dma_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  dma_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .xfer_req  (xfer_req),
    .bus_grant (bus_grant),
    .last_byte (last_byte),
    .state     (state),
    .loop_back (loop_back)
  );

  assign load_en = (state == ST_IDLE);

  dma_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_en    (load_en),
    .step_en    (loop_back),
    .start_addr (start_addr),
    .addr       (addr)
  );

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state == ST_CHK && !last_byte) |=> (addr == $past(addr) + 1'b1)); // R8
  AST_ADDR_KEEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state == ST_HOLD || state == ST_DATA || state == ST_ACK) |=> $stable(addr)); // R8

  dma_phase_dec #(.DATA_W(DATA_W)) u_dec (
    .state       (state),
    .mem_rdata   (mem_rdata),
    .hold_req    (hold_req),
    .addr_en_n   (addr_en_n),
    .addr_stb    (addr_stb),
    .dout        (dout),
    .io_ack      (io_ack),
    .io_strobe_n (io_strobe_n)
  );

  AST_HOLD_DROP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state == ST_CHK && last_byte) |=> !hold_req); // R3
  AST_ACK_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_sync_n)
    io_ack |-> ($past(state) == ST_DATA)); // R6

endmodule

// File: tb/sim_dma_mem2io_ctrl.sv
`timescale 1ns/1ps
module sim_dma_mem2io_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        xfer_req, bus_grant, last_byte;
  logic [11:0] start_addr;
  logic [7:0]  mem_rdata;
  logic        hold_req, addr_en_n, addr_stb, io_ack, io_strobe_n;
  logic [7:0]  dout;
  logic [11:0] addr;

  int n_cmp = 0;
  int n_bad = 0;
  logic [24:0] expq[$];
  string       tagq[$];

  always #2 clk = ~clk;

  dma_mem2io_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .bus_grant(bus_grant),
    .last_byte(last_byte), .start_addr(start_addr), .mem_rdata(mem_rdata),
    .hold_req(hold_req), .addr_en_n(addr_en_n), .addr_stb(addr_stb),
    .dout(dout), .io_ack(io_ack), .io_strobe_n(io_strobe_n), .addr(addr)
  );

  function automatic logic [24:0] ex(input logic h, ae, as, input logic [7:0] d,
                                     input logic ak, ios, input logic [11:0] a);
    return {h, ae, as, d, ak, ios, a};
  endfunction
  function automatic logic [24:0] e_idle(input logic [11:0] a); return ex(0,1,0,8'h00,0,1,a); endfunction
  function automatic logic [24:0] e_hold(input logic [11:0] a); return ex(1,1,0,8'h00,0,1,a); endfunction
  function automatic logic [24:0] e_adr(input logic [11:0] a);  return ex(1,0,1,8'h00,0,1,a); endfunction
  function automatic logic [24:0] e_dat(input logic [11:0] a, input logic [7:0] d); return ex(1,1,0,d,0,1,a); endfunction
  function automatic logic [24:0] e_ack(input logic [11:0] a);  return ex(1,1,0,8'h00,1,0,a); endfunction

  function automatic logic [24:0] outs();
    return {hold_req, addr_en_n, addr_stb, dout, io_ack, io_strobe_n, addr};
  endfunction

  task automatic check_now(input logic [24:0] e, input string tag);
    n_cmp++;
    if (outs() !== e) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, outs(), e);
    end
  endtask

  // driver: apply inputs at the falling edge, queue the outputs due after the next rising edge
  task automatic step(input logic r, g, l, input logic [11:0] sa, input logic [7:0] rd,
                      input logic [24:0] e, input string tag);
    @(negedge clk);
    xfer_req = r; bus_grant = g; last_byte = l; start_addr = sa; mem_rdata = rd;
    expq.push_back(e);
    tagq.push_back(tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expq.size() > 0) check_now(expq.pop_front(), tagq.pop_front());
    end
  end

  initial begin
    #(4 * 20000);
    n_bad++;
    $display("FAIL R1..R8 watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; xfer_req = 0; bus_grant = 0; last_byte = 0;
    start_addr = 12'h000; mem_rdata = 8'h00;
    repeat (3) @(posedge clk);
    #1 check_now(e_idle(12'h000), "R1 reset state");
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // three-byte run from 0x123
    step(0,0,0,12'h123,8'h00, e_idle(12'h123), "R8 idle load");
    step(1,0,0,12'h123,8'h00, e_hold(12'h123), "R2 request");
    step(0,0,1,12'h7FF,8'h00, e_hold(12'h123), "R3 wait grant");
    step(0,1,0,12'h7FF,8'h00, e_adr(12'h123),  "R4 address phase");
    step(0,0,1,12'h7FF,8'hA5, e_dat(12'h123,8'hA5), "R5 data byte0");
    step(1,1,1,12'h7FF,8'hA5, e_ack(12'h123),  "R6 ack byte0");
    step(0,0,1,12'h7FF,8'h11, e_hold(12'h123), "R7 check byte0");
    step(0,0,0,12'h7FF,8'h3C, e_dat(12'h124,8'h3C), "R8 step to byte1");
    step(0,0,1,12'h7FF,8'h3C, e_ack(12'h124),  "R6 ack byte1");
    step(0,0,0,12'h7FF,8'h00, e_hold(12'h124), "R7 check byte1");
    step(0,0,0,12'h7FF,8'h5A, e_dat(12'h125,8'h5A), "R7 loop skips address");
    step(0,0,0,12'h7FF,8'h00, e_ack(12'h125),  "R6 ack byte2");
    step(0,0,0,12'h7FF,8'h00, e_hold(12'h125), "R4 check byte2");
    step(0,0,1,12'h7FF,8'h00, e_idle(12'h125), "R3 hold drops at exit");
    step(0,0,0,12'h7FF,8'h00, e_idle(12'h7FF), "R8 reload in idle");

    // wrap past 0xFFF, then a back-to-back request on the exit edge
    step(0,0,0,12'hFFF,8'h00, e_idle(12'hFFF), "R8 idle load");
    step(1,1,0,12'hFFF,8'h00, e_hold(12'hFFF), "R2 request");
    step(1,1,0,12'hFFF,8'h00, e_adr(12'hFFF),  "R4 immediate grant");
    step(1,0,0,12'hFFF,8'hC3, e_dat(12'hFFF,8'hC3), "R5 data");
    step(1,0,0,12'hFFF,8'hC3, e_ack(12'hFFF),  "R5 dout zero in ack");
    step(1,0,0,12'hFFF,8'h00, e_hold(12'hFFF), "R7 check");
    step(1,0,0,12'hFFF,8'h99, e_dat(12'h000,8'h99), "R8 wrap");
    step(1,0,0,12'hFFF,8'h00, e_ack(12'h000),  "R6 ack");
    step(1,0,0,12'hFFF,8'h00, e_hold(12'h000), "R7 check");
    step(1,0,1,12'hFFF,8'h00, e_idle(12'h000), "R7 end");
    step(1,0,0,12'hFFF,8'h00, e_hold(12'hFFF), "R2 back-to-back");
    step(0,1,0,12'hFFF,8'h00, e_adr(12'hFFF),  "R4 address");
    step(0,0,0,12'hFFF,8'h77, e_dat(12'hFFF,8'h77), "R5 single byte");
    step(0,0,0,12'hFFF,8'h00, e_ack(12'hFFF),  "R6 ack");
    step(0,0,0,12'hFFF,8'h00, e_hold(12'hFFF), "R7 check");
    step(0,0,1,12'hFFF,8'h00, e_idle(12'hFFF), "R7 single end");

    // asynchronous reset in the middle of a run
    step(1,0,0,12'h0AB,8'h00, e_hold(12'h0AB), "R2 request");
    step(0,1,0,12'h0AB,8'h00, e_adr(12'h0AB),  "R4 address");
    @(posedge clk);
    #1.5 rst_n = 1'b0;
    #0.2 check_now(e_idle(12'h000), "R1 async reset mid-run");
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule